// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Sequencer

This block turns single register-bus requests into programmed-I/O read and write cycles on a parallel ATA bus. It owns a small bank of internal registers: one control word, one status word, a timing word shared by both devices, and one fast timing word per device. A request whose address targets the bus side is played out as a sequence of phases. First an address setup phase, then a strobe pulse, then a data hold phase, and last one closing clock. The length of each phase comes from the selected timing word.

The timing word is chosen when the cycle starts. It depends on the currently selected device and on that device's fast-timing enable. The device selection is taken from writes to the ATA drive/head register. While the honouring of the device ready line is enabled for the timing set in use, the device can stretch the strobe. An optional one-entry write slot lets software post a second write while a cycle is still running. The block reports a busy flag, a slot-full flag and a one-clock completion pulse.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset the control word reads 0, all three timing words read the default 0x1D032408, no chip select or strobe is asserted (cs_n = 2'b11, both strobes high), the data bus is not driven and busy is low.
- R2: A request with address bit 6 clear accesses an internal register selected by address bits 4:2 (0 control, 1 status, 2 shared timing, 3 fast timing device 0, 4 fast timing device 1). It raises rsp_done on the clock after acceptance and starts no bus activity. A read returns the register value on rsp_rdata.
- R3: A request with address bit 6 set while control bit 7 (core enable) is clear completes with rsp_done on the next clock and produces no strobe.
- R4: Each timing word holds the setup count in bits 7:0, the strobe count in bits 15:8 and the hold count in bits 23:16. A bus cycle holds chip select and DA stable for setup+1 clocks before the strobe, asserts the strobe for strobe+1 clocks, waits hold+1 clocks, and ends with one closing clock in which rsp_done pulses for exactly one clock. Address bit 5 picks cs_n[1] (set) or cs_n[0] (clear), and address bits 4:2 drive DA.
- R5: In a write cycle only the write strobe pulses, and the write data is driven with the output enable from the first setup clock to the last hold clock. The bus is released in the closing clock.
- R6: In a read cycle only the read strobe pulses, the bus is never driven, and the data present on the last strobe clock is returned in the low bits of rsp_rdata with rsp_done.
- R7: Control bit 5 (device 0) and bit 6 (device 1) make cycles to that device use its own fast timing word. When the bit is clear, the cycle uses the shared timing word.
- R8: A bus write to the drive/head register (address bit 5 clear, DA = 6) selects the device given by data bit 4. The selection applies from the next cycle on.
- R9: Ready-line honouring is enabled by control bit 1 for the shared set, bit 2 for device 0 fast timing and bit 3 for device 1 fast timing. Only the bit of the set in use counts. When that bit is set and the ready line is low at the last strobe clock, the strobe stays asserted until the clock after the ready line is seen high, and then the hold phase starts.
- R10: pio_busy and status bit 7 are high from the first setup clock through the closing clock of every bus cycle, and low otherwise.
- R11: With control bit 4 set, one bus write may be accepted while a cycle runs (not in its closing clock). pp_full and status bit 6 stay high until the posted write starts. It starts on the clock right after the closing clock of the current cycle.
- R12: With control bit 4 clear, req_ready is low while a bus cycle runs.
- R13: Control bit 0 drives the bus reset line: ata_reset_n is low while the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_addr | input | ADDR_W | Request address (bit 6 picks bus or internal space) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data (low DD_W bits go to the bus) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_done of a read |
| pio_busy | output | 1 | Bus cycle in progress |
| pp_full | output | 1 | Posted write slot occupied |
| ata_reset_n | output | 1 | Bus reset line, active low |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DD_W | Data driven to the bus |
| ata_dd_oe | output | 1 | Data output enable |
| ata_dd_in | input | DD_W | Data sampled from the bus |
| ata_iordy | input | 1 | Device ready line |

## Verification
A phase counter that is loaded wrongly or released one clock late shows at once as a strobe pulse or setup window of the wrong length. The bench counts these per clock at the strobe and chip-select pins, within a single cycle of ten or so clocks. A device selection or timing-set choice that latches at the wrong moment shows up as the wrong strobe width on the next cycle. A slot that is lost or that launches late shows as a missing second completion pulse, or one that arrives at the wrong clock count. A read capture taken at the wrong clock returns the bus value that the bench drives only outside the last strobe clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int WORD_W  = 32;
   localparam int FIELD_W = 8;
   localparam int CTRL_W  = 8;
   localparam int NDEV    = 2;

   // control word bit positions
   localparam int CTL_BUSRST    = 0;
   localparam int CTL_IORDY_CMD = 1;
   localparam int CTL_IORDY_F0  = 2;
   localparam int CTL_PP        = 4;
   localparam int CTL_FAST0     = 5;
   localparam int CTL_EN        = 7;

   // status word bit positions
   localparam int ST_PP_FULL = 6;
   localparam int ST_BUSY    = 7;

   // internal register index (address bits 4:2)
   localparam logic [2:0] IDX_CTRL  = 3'd0;
   localparam logic [2:0] IDX_STAT  = 3'd1;
   localparam logic [2:0] IDX_CMD   = 3'd2;
   localparam logic [2:0] IDX_FAST0 = 3'd3;

   // bus address {cs select, DA} of the drive/head register and its device bit
   localparam logic [3:0] DEVHEAD_ADDR = 4'b0110;
   localparam int         DEV_BIT      = 4;

   typedef struct packed {
      logic [FIELD_W-1:0] hold;
      logic [FIELD_W-1:0] pulse;
      logic [FIELD_W-1:0] setup;
   } phase_t;

   localparam int PHASE_W = $bits(phase_t);

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_STROBE, PH_WAIT, PH_HOLD, PH_CLOSE
   } phase_e;
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
   import pio_pkg::*;
#(
   parameter logic [WORD_W-1:0] DEF_TIMING = 32'h1D03_2408
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           idx,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 busy,
   input  logic                 slot_full,
   output logic [CTRL_W-1:0]    ctrl,
   output phase_t               cmd_ph,
   output phase_t [NDEV-1:0]    fast_ph,
   output logic [WORD_W-1:0]    rdata
);
   logic [CTRL_W-1:0] ctrl_q;
   logic [WORD_W-1:0] cmd_q;
   logic [WORD_W-1:0] fast_q [NDEV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmd_q  <= DEF_TIMING;
      end else if (wr_en) begin
         if (idx == IDX_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
         if (idx == IDX_CMD)  cmd_q  <= wdata;
      end
   end

   for (genvar d = 0; d < NDEV; d++) begin : g_fast
      localparam logic [2:0] MY_IDX = 3'(int'(IDX_FAST0) + d);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       fast_q[d] <= DEF_TIMING;
         else if (wr_en && idx == MY_IDX)  fast_q[d] <= wdata;
      end
      assign fast_ph[d] = fast_q[d][PHASE_W-1:0];
   end

   assign ctrl   = ctrl_q;
   assign cmd_ph = cmd_q[PHASE_W-1:0];

   always_comb begin
      rdata = '0;
      case (idx)
         IDX_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
         IDX_STAT: begin
            rdata[ST_BUSY]    = busy;
            rdata[ST_PP_FULL] = slot_full;
         end
         IDX_CMD:       rdata = cmd_q;
         IDX_FAST0:     rdata = fast_q[0];
         IDX_FAST0 + 1: rdata = fast_q[1];
         default:       rdata = '0;
      endcase
   end
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
   import pio_pkg::*;
(
   input  logic [CTRL_W-1:0]  ctrl,
   input  logic               dev_sel,
   input  phase_t             cmd_ph,
   input  phase_t [NDEV-1:0]  fast_ph,
   output phase_t             sel_ph,
   output logic               sel_iordy
);
   logic fast_on;

   always_comb begin
      fast_on   = ctrl[CTL_FAST0 + int'(dev_sel)];
      sel_ph    = fast_on ? fast_ph[dev_sel] : cmd_ph;
      sel_iordy = fast_on ? ctrl[CTL_IORDY_F0 + int'(dev_sel)] : ctrl[CTL_IORDY_CMD];
   end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
   import pio_pkg::*;
#(
   parameter int DD_W        = 16,
   parameter int IORDY_SYNC  = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            push,
   input  logic [3:0]      in_addr,
   input  logic            in_write,
   input  logic [DD_W-1:0] in_wdata,
   input  phase_t          sel_ph,
   input  logic            sel_iordy,
   input  logic            iordy,
   input  logic [DD_W-1:0] dd_in,
   output logic            busy,
   output logic            in_close,
   output logic            slot_full,
   output logic            dev_sel,
   output logic            rd_cap,
   output logic [1:0]      cs_n,
   output logic [2:0]      da,
   output logic            dior_n,
   output logic            diow_n,
   output logic [DD_W-1:0] dd_out,
   output logic            dd_oe
);
   phase_e             state;
   logic [FIELD_W-1:0] cnt;
   phase_t             ph_q;
   logic               iord_q;
   logic [3:0]         cur_addr, slot_addr, ln_addr;
   logic               cur_write, ln_write, ln_go;
   logic [DD_W-1:0]    cur_wdata, slot_wdata, ln_wdata;
   logic               iordy_s, stretch, strobe_on;

   // ready line path: direct or through a synchronizer chain
   if (IORDY_SYNC == 0) begin : g_iordy_direct
      assign iordy_s = iordy;
   end else begin : g_iordy_sync
      logic [IORDY_SYNC-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= (sh << 1) | IORDY_SYNC'(iordy);
      end
      assign iordy_s = sh[IORDY_SYNC-1];
   end

   always_comb begin
      ln_go    = (state == PH_IDLE && start) || (state == PH_CLOSE && slot_full);
      ln_addr  = (state == PH_CLOSE) ? slot_addr  : in_addr;
      ln_write = (state == PH_CLOSE) ? 1'b1       : in_write;
      ln_wdata = (state == PH_CLOSE) ? slot_wdata : in_wdata;
      stretch  = iord_q && !iordy_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PH_IDLE;
         cnt        <= '0;
         ph_q       <= '0;
         iord_q     <= 1'b0;
         cur_addr   <= '0;
         cur_write  <= 1'b0;
         cur_wdata  <= '0;
         slot_addr  <= '0;
         slot_wdata <= '0;
         slot_full  <= 1'b0;
         dev_sel    <= 1'b0;
      end else begin
         case (state)
            PH_SETUP: if (cnt == 0) begin
                         state <= PH_STROBE;
                         cnt   <= ph_q.pulse;
                      end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt != 0) cnt <= cnt - 1'b1;
                       else if (stretch) state <= PH_WAIT;
                       else begin
                          state <= PH_HOLD;
                          cnt   <= ph_q.hold;
                       end
            PH_WAIT: if (iordy_s) begin
                        state <= PH_HOLD;
                        cnt   <= ph_q.hold;
                     end
            PH_HOLD: if (cnt == 0) state <= PH_CLOSE;
                     else          cnt   <= cnt - 1'b1;
            PH_CLOSE: state <= PH_IDLE;
            default: ;
         endcase
         if (ln_go) begin
            state     <= PH_SETUP;
            cnt       <= sel_ph.setup;
            ph_q      <= sel_ph;
            iord_q    <= sel_iordy;
            cur_addr  <= ln_addr;
            cur_write <= ln_write;
            cur_wdata <= ln_wdata;
            if (ln_write && ln_addr == DEVHEAD_ADDR) dev_sel <= ln_wdata[DEV_BIT];
         end
         if (state == PH_CLOSE && slot_full) slot_full <= 1'b0;
         if (push) begin
            slot_full  <= 1'b1;
            slot_addr  <= in_addr;
            slot_wdata <= in_wdata;
         end
      end
   end

   assign busy      = (state != PH_IDLE);
   assign in_close  = (state == PH_CLOSE);
   assign strobe_on = (state == PH_STROBE) || (state == PH_WAIT);
   assign rd_cap    = !cur_write &&
                      ((state == PH_STROBE && cnt == 0 && !stretch) ||
                       (state == PH_WAIT && iordy_s));
   assign dior_n    = !(strobe_on && !cur_write);
   assign diow_n    = !(strobe_on && cur_write);
   assign cs_n      = !busy ? 2'b11 : (cur_addr[3] ? 2'b01 : 2'b10);
   assign da        = busy ? cur_addr[2:0] : 3'd0;
   assign dd_out    = cur_wdata;
   assign dd_oe     = cur_write && busy && !in_close;
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
   import pio_pkg::*;
#(
   parameter int                ADDR_W     = 7,
   parameter int                DD_W       = 16,
   parameter int                IORDY_SYNC = 0,
   parameter logic [WORD_W-1:0] DEF_TIMING = 32'h1D03_2408
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               rsp_done,
   output logic [WORD_W-1:0]  rsp_rdata,
   output logic               pio_busy,
   output logic               pp_full,
   output logic               ata_reset_n,
   output logic [1:0]         ata_cs_n,
   output logic [2:0]         ata_da,
   output logic               ata_dior_n,
   output logic               ata_diow_n,
   output logic [DD_W-1:0]    ata_dd_out,
   output logic               ata_dd_oe,
   input  logic [DD_W-1:0]    ata_dd_in,
   input  logic               ata_iordy
);
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must cover address bit 6");
   end
   if (DD_W < 8 || DD_W > WORD_W) begin : g_bad_dd
      $error("DD_W must lie between 8 and the word width");
   end
   if (IORDY_SYNC < 0 || IORDY_SYNC > 4) begin : g_bad_sync
      $error("IORDY_SYNC must lie between 0 and 4");
   end

   logic [CTRL_W-1:0] ctrl;
   phase_t            cmd_ph, sel_ph;
   phase_t [NDEV-1:0] fast_ph;
   logic [WORD_W-1:0] cfg_rdata, rdata_q;
   logic              sel_iordy, dev_sel, busy, in_close, slot_full, rd_cap;
   logic              is_bus, core_en, pp_en, accept, start_bus, push, local_acc;
   logic              done_q, unused_bits;

   assign is_bus  = req_addr[6];
   assign core_en = ctrl[CTL_EN];
   assign pp_en   = ctrl[CTL_PP];

   always_comb begin
      req_ready = !busy ||
                  (!in_close && pp_en && !slot_full && req_write && is_bus && core_en);
      accept    = req_valid && req_ready;
      start_bus = accept && !busy && is_bus && core_en;
      push      = accept && busy;
      local_acc = accept && !busy && !start_bus;
   end

   pio_cfg_regs #(.DEF_TIMING(DEF_TIMING)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (local_acc && req_write && !is_bus),
      .idx       (req_addr[4:2]),
      .wdata     (req_wdata),
      .busy      (busy),
      .slot_full (slot_full),
      .ctrl      (ctrl),
      .cmd_ph    (cmd_ph),
      .fast_ph   (fast_ph),
      .rdata     (cfg_rdata)
   );

   pio_timing_sel i_sel (
      .ctrl      (ctrl),
      .dev_sel   (dev_sel),
      .cmd_ph    (cmd_ph),
      .fast_ph   (fast_ph),
      .sel_ph    (sel_ph),
      .sel_iordy (sel_iordy)
   );

   pio_phase_fsm #(.DD_W(DD_W), .IORDY_SYNC(IORDY_SYNC)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_bus),
      .push      (push),
      .in_addr   (req_addr[5:2]),
      .in_write  (req_write),
      .in_wdata  (req_wdata[DD_W-1:0]),
      .sel_ph    (sel_ph),
      .sel_iordy (sel_iordy),
      .iordy     (ata_iordy),
      .dd_in     (ata_dd_in),
      .busy      (busy),
      .in_close  (in_close),
      .slot_full (slot_full),
      .dev_sel   (dev_sel),
      .rd_cap    (rd_cap),
      .cs_n      (ata_cs_n),
      .da        (ata_da),
      .dior_n    (ata_dior_n),
      .diow_n    (ata_diow_n),
      .dd_out    (ata_dd_out),
      .dd_oe     (ata_dd_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= local_acc;
         if (local_acc)   rdata_q <= is_bus ? '0 : cfg_rdata;
         else if (rd_cap) rdata_q <= WORD_W'(ata_dd_in);
      end
   end

   assign rsp_done    = done_q || in_close;
   assign rsp_rdata   = rdata_q;
   assign pio_busy    = busy;
   assign pp_full     = slot_full;
   assign ata_reset_n = !ctrl[CTL_BUSRST];
   assign unused_bits = ^{req_addr, req_wdata};
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       pio_busy,
   input logic       pp_full,
   input logic       pp_en,
   input logic       rsp_done,
   input logic       ata_dior_n,
   input logic       ata_diow_n,
   input logic       ata_dd_oe,
   input logic [1:0] ata_cs_n
);
   // R10
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |-> pio_busy);

   // R5
   write_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_diow_n |-> ata_dd_oe);

   // R6
   read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_dior_n |-> !ata_dd_oe);

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && pio_busy) |=> !rsp_done);

   // R4
   addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ata_dior_n) || $fell(ata_diow_n)) |-> ($stable(ata_cs_n) && ata_cs_n != 2'b11));

   // R11
   slot_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pp_full |-> pio_busy);

   // R12
   no_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_busy && !pp_en) |-> !req_ready);
endmodule

bind pio_cycle_engine pio_cycle_engine_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .pio_busy   (pio_busy),
   .pp_full    (pp_full),
   .pp_en      (pp_en),
   .rsp_done   (rsp_done),
   .ata_dior_n (ata_dior_n),
   .ata_diow_n (ata_diow_n),
   .ata_dd_oe  (ata_dd_oe),
   .ata_cs_n   (ata_cs_n)
);

// File: tb/test_pio_cycle_engine.sv
module test_pio_cycle_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [6:0]  req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic        pio_busy, pp_full, ata_reset_n;
   logic [1:0]  ata_cs_n;
   logic [2:0]  ata_da;
   logic        ata_dior_n, ata_diow_n, ata_dd_oe;
   logic [15:0] ata_dd_out;
   logic [15:0] ata_dd_in = '0;
   logic        ata_iordy = 1'b1;

   localparam logic [31:0] DEF_T = 32'h1D03_2408;
   localparam logic [31:0] T_CMD = 32'h0501_0302; // setup 2, pulse 3, hold 1
   localparam logic [31:0] T_F0  = 32'h0400_0501; // setup 1, pulse 5, hold 0
   localparam logic [31:0] T_F1  = 32'h0302_0100; // setup 0, pulse 1, hold 2

   int n_cmp = 0;
   int n_bad = 0;

   // results of one bus cycle
   int          r_total, r_rds, r_wrs, r_pre, r_oe, r_busy;
   logic        r_oe_end;
   logic [1:0]  r_cs;
   logic [2:0]  r_da;
   logic [15:0] r_dd;
   logic [31:0] r_rdata;
   logic        r_ready;

   always #4 clk = ~clk;

   pio_cycle_engine i_pio_cycle_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .pio_busy(pio_busy),
      .pp_full(pp_full), .ata_reset_n(ata_reset_n), .ata_cs_n(ata_cs_n),
      .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
      .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
      .ata_iordy(ata_iordy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_addr = {2'b00, idx, 2'b00}; req_write = 1'b1; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 internal write done", {31'd0, rsp_done}, 32'd1);
   endtask

   task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_addr = {2'b00, idx, 2'b00}; req_write = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 internal read done", {31'd0, rsp_done}, 32'd1);
      d = rsp_rdata;
   endtask

   // one bus cycle; rel: clock count at which the ready line is raised (0: never)
   // dv_at: clock count during which dd_in carries dv (0: never)
   task automatic bus_cycle(input logic cs1, input logic [2:0] da, input logic wr,
                            input logic [15:0] wd, input int rel,
                            input int dv_at, input logic [15:0] dv);
      @(negedge clk);
      req_valid = 1'b1; req_addr = {1'b1, cs1, da, 2'b00}; req_write = wr;
      req_wdata = {16'h0, wd};
      r_ready = req_ready;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      r_total = 0; r_rds = 0; r_wrs = 0; r_pre = 0; r_oe = 0; r_busy = 0;
      for (int k = 0; k < 3000; k++) begin
         r_total++;
         if (r_total == rel) ata_iordy = 1'b1;
         if (r_total == dv_at) ata_dd_in = dv;
         else if (r_total == dv_at + 1) ata_dd_in = 16'h0;
         if (r_total == 1) begin r_cs = ata_cs_n; r_da = ata_da; r_dd = ata_dd_out; end
         if (!ata_dior_n) r_rds++;
         if (!ata_diow_n) r_wrs++;
         if (ata_dior_n && ata_diow_n && r_rds == 0 && r_wrs == 0) r_pre++;
         if (ata_dd_oe) r_oe++;
         if (pio_busy) r_busy++;
         if (rsp_done) begin r_rdata = rsp_rdata; r_oe_end = ata_dd_oe; break; end
         @(negedge clk);
      end
      ata_dd_in = 16'h0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 cs idle", {30'd0, ata_cs_n}, 32'd3);
      chk("R1 strobes idle", {30'd0, ata_dior_n, ata_diow_n}, 32'd3);
      chk("R1 bus released", {31'd0, ata_dd_oe}, 32'd0);
      chk("R1 busy low", {31'd0, pio_busy}, 32'd0);
      chk("R13 reset line idle", {31'd0, ata_reset_n}, 32'd1);
      reg_rd(3'd0, d); chk("R1 control reset", d, 32'd0);
      reg_rd(3'd2, d); chk("R1 shared timing reset", d, DEF_T);
      reg_rd(3'd3, d); chk("R1 fast0 reset", d, DEF_T);
      reg_rd(3'd4, d); chk("R1 fast1 reset", d, DEF_T);
      reg_rd(3'd1, d); chk("R10 status idle", d, 32'd0);
   endtask

   task automatic t_disabled;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 7'b100_0000; req_write = 1'b1; req_wdata = 32'h55;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 done without cycle", {31'd0, rsp_done}, 32'd1);
      chk("R3 not busy", {31'd0, pio_busy}, 32'd0);
      for (int k = 0; k < 4; k++) begin
         chk("R3 no strobe", {30'd0, ata_dior_n, ata_diow_n}, 32'd3);
         @(negedge clk);
      end
   endtask

   task automatic t_write_read;
      logic [31:0] d;
      reg_wr(3'd2, T_CMD);
      reg_wr(3'd0, 32'h80);
      chk("R2 no bus activity on internal write", {30'd0, ata_cs_n}, 32'd3);
      reg_rd(3'd2, d); chk("R2 timing readback", d, T_CMD);
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h1234, 0, 0, 16'h0);
      chk("R4 total clocks", r_total, 10);
      chk("R4 setup clocks", r_pre, 3);
      chk("R4 strobe clocks", r_wrs, 4);
      chk("R5 read strobe quiet", r_rds, 0);
      chk("R5 drive clocks", r_oe, 9);
      chk("R5 released at close", {31'd0, r_oe_end}, 32'd0);
      chk("R5 write data", {16'd0, r_dd}, 32'h1234);
      chk("R4 cs0 select", {30'd0, r_cs}, 32'd2);
      chk("R10 busy clocks", r_busy, 10);
      @(negedge clk);
      chk("R4 done one clock", {31'd0, rsp_done}, 32'd0);
      chk("R10 busy cleared", {31'd0, pio_busy}, 32'd0);
      bus_cycle(1'b1, 3'd6, 1'b1, 16'h0004, 0, 0, 16'h0);
      chk("R4 cs1 select", {30'd0, r_cs}, 32'd1);
      chk("R4 DA value", {29'd0, r_da}, 32'd6);
      bus_cycle(1'b0, 3'd7, 1'b0, 16'h0, 0, 7, 16'hBEEF);
      chk("R6 read strobe clocks", r_rds, 4);
      chk("R6 write strobe quiet", r_wrs, 0);
      chk("R6 bus never driven", r_oe, 0);
      chk("R6 captured data", r_rdata, 32'h0000BEEF);
   endtask

   task automatic t_select;
      reg_wr(3'd3, T_F0);
      reg_wr(3'd0, 32'hA0);
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h0001, 0, 0, 16'h0);
      chk("R7 device0 fast strobe", r_wrs, 6);
      chk("R7 device0 fast setup", r_pre, 2);
      bus_cycle(1'b0, 3'd6, 1'b1, 16'h0010, 0, 0, 16'h0);
      chk("R8 select uses old device", r_wrs, 6);
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h0002, 0, 0, 16'h0);
      chk("R8 device1 shared strobe", r_wrs, 4);
      chk("R7 fast bit clear uses shared", r_pre, 3);
      reg_wr(3'd4, T_F1);
      reg_wr(3'd0, 32'hE0);
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h0003, 0, 0, 16'h0);
      chk("R7 device1 fast strobe", r_wrs, 2);
      chk("R7 device1 fast total", r_total, 7);
   endtask

   task automatic t_iordy;
      reg_wr(3'd0, 32'hE2);
      ata_iordy = 1'b0;
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h0005, 0, 0, 16'h0);
      ata_iordy = 1'b1;
      chk("R9 other set bit ignored", r_wrs, 2);
      reg_wr(3'd0, 32'hEA);
      ata_iordy = 1'b0;
      bus_cycle(1'b0, 3'd0, 1'b1, 16'h0006, 6, 0, 16'h0);
      chk("R9 device1 stretch strobe", r_wrs, 5);
      chk("R9 device1 stretch total", r_total, 10);
      bus_cycle(1'b0, 3'd6, 1'b1, 16'h0000, 0, 0, 16'h0);
      reg_wr(3'd0, 32'h82);
      ata_iordy = 1'b0;
      bus_cycle(1'b0, 3'd1, 1'b0, 16'h0, 10, 10, 16'hA5C3);
      chk("R9 shared stretch strobe", r_rds, 7);
      chk("R9 shared stretch total", r_total, 13);
      chk("R6 stretched read data", r_rdata, 32'h0000A5C3);
   endtask

   task automatic t_bus_reset;
      reg_wr(3'd0, 32'h81);
      chk("R13 reset line asserted", {31'd0, ata_reset_n}, 32'd0);
      reg_wr(3'd0, 32'h80);
      chk("R13 reset line released", {31'd0, ata_reset_n}, 32'd1);
   endtask

   task automatic t_posting;
      int first, second, wrs;
      logic [31:0] d;
      // without posting
      @(negedge clk);
      req_valid = 1'b1; req_addr = 7'b100_0000; req_write = 1'b1; req_wdata = 32'h7;
      @(posedge clk);
      @(negedge clk);
      req_addr = 7'b100_0100;
      chk("R12 not ready while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 20; k++) @(negedge clk);
      chk("R12 second write dropped", {31'd0, pio_busy}, 32'd0);
      // with posting
      reg_wr(3'd0, 32'h90);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 7'b100_0000; req_wdata = 32'h1111;
      @(posedge clk);
      @(negedge clk);
      req_addr = 7'b100_0100; req_wdata = 32'h2222;
      chk("R11 ready while running", {31'd0, req_ready}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11 slot full", {31'd0, pp_full}, 32'd1);
      first = 0; second = 0; wrs = 0;
      for (int c = 2; c < 40; c++) begin
         if (!ata_diow_n) wrs++;
         if (c == 11) begin
            chk("R11 slot freed at launch", {31'd0, pp_full}, 32'd0);
            chk("R11 posted DA", {29'd0, ata_da}, 32'd1);
            chk("R11 posted data", {16'd0, ata_dd_out}, 32'h2222);
         end
         if (rsp_done) begin
            if (first == 0) first = c; else if (second == 0) second = c;
         end
         @(negedge clk);
      end
      chk("R11 first done clock", first, 10);
      chk("R11 posted done clock", second, 20);
      chk("R11 both strobes", wrs, 8);
      reg_rd(3'd1, d); chk("R11 status slot clear", d, 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      report;
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_disabled;
      t_write_read;
      t_select;
      t_iordy;
      t_bus_reset;
      t_posting;
      report;
      $finish;
   end
endmodule